// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

This block takes a signed 64-bit two's-complement integer and writes it out as an 80-bit packed-decimal value. The result is split into a 64-bit low part and a 16-bit high part. The low part holds sixteen 4-bit decimal digits. The high part holds two more digits and a sign bit. A request is made with a one-cycle start strobe, which carries the integer and three qualifiers:
- a flag saying an earlier conversion step already found the operand invalid;
- a flag saying the operand register was empty;
- a mask bit that selects how an invalid operation is handled.

A valid operand is first reduced to its magnitude, and its sign is kept aside. The magnitude is then divided by ten once per clock, for eighteen clocks. Each remainder becomes one decimal digit, starting with the least significant.

An operand is invalid when its magnitude has more than eighteen decimal digits, when either input flag is set, or when it is the most negative 64-bit value. With the mask set, an invalid operand produces a fixed "indefinite" pattern, which is written out. With the mask clear, nothing is written and only the invalid flag is raised. Results go out with a one-cycle done pulse, together with a write enable when the result is to be stored.

Top module: `bcd_packer`

## Requirements
- R1: While reset is applied and after it is released, done, write enable and invalid are low, and both result parts read zero.
- R2: For a valid operand, decimal digit i (i = 0 is the least significant) is placed in low-part bits [4i+3:4i] for i = 0 to 15. Digit 16 is placed in high-part bits [3:0] and digit 17 in high-part bits [7:4]. High-part bits [14:8] are zero.
- R3: High-part bit 15 is 1 for a valid negative operand and 0 for a valid non-negative operand. The digits always encode the magnitude.
- R4: An operand whose magnitude is at most 999999999999999999 is valid. A larger magnitude is invalid, and so is the most negative 64-bit value.
- R5: An invalid operand with the mask set produces a high part of 0xFFFF and a low part of 0xC000000000000000, with write enable and invalid both high.
- R6: An invalid operand with the mask clear raises invalid with write enable low, and both result parts keep their previous values.
- R7: An empty-operand flag makes the request invalid, whatever the integer is.
- R8: An upstream-invalid flag makes the request invalid, whatever the integer is.
- R9: Let start be sampled at rising edge k. A valid request has done high from edge k+18 to edge k+19. An invalid request has done high from edge k to edge k+1.
- R10: Done lasts exactly one cycle. Write enable and invalid are high only while done is high.
- R11: A start strobe that arrives while a conversion is in progress is ignored. The running conversion completes unchanged, and no extra done follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| value_i | input | 64 | Signed operand |
| src_invalid_i | input | 1 | Operand already flagged invalid upstream |
| stack_empty_i | input | 1 | Operand register empty |
| inv_mask_i | input | 1 | 1: store indefinite on invalid; 0: suppress store |
| lo_o | output | 64 | Digits 0 to 15 |
| hi_o | output | 16 | Sign, zero padding, digits 16 and 17 |
| wr_en_o | output | 1 | Store the result (pulses with done) |
| invalid_o | output | 1 | Invalid operation (pulses with done) |
| done_o | output | 1 | Conversion finished |

## Verification
Each error shows up at the ports with a known delay:
- A wrong digit count or a misaligned shift puts a digit into the wrong nibble. It becomes visible on the done pulse, eighteen cycles after start.
- A controller stuck in the running state shows as a missing or late done, and a result that is not in the expected cycle.
- A fault taking the wrong path shows in the very next cycle: a write where none belongs, or a digit pattern where the indefinite code belongs.
- A result register that is disturbed outside a done cycle is seen by the output-stability check, and by the unmasked case, which must leave the previous result in place.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int VAL_W  = 64;
  localparam int NDIG   = 18;
  localparam int DIG_W  = 4;
  localparam int LO_W   = 64;
  localparam int HI_W   = 16;
  localparam logic [VAL_W-1:0] MAG_LIMIT = 64'd999999999999999999;
  localparam logic [LO_W-1:0]  INDEF_LO  = 64'hC000_0000_0000_0000;
  localparam logic [HI_W-1:0]  INDEF_HI  = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bcd_range_check.sv
module bcd_range_check #(
  parameter int                 W     = 64,
  parameter logic [W-1:0]       LIMIT = '1
) (
  input  logic [W-1:0] value_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o,
  output logic         over_o
);
  always_comb begin
    neg_o  = value_i[W-1];
    mag_o  = neg_o ? (~value_i + {{(W-1){1'b0}}, 1'b1}) : value_i;
    // the most negative value negates to itself, a magnitude above any limit
    over_o = (mag_o > LIMIT);
  end
endmodule

// File: rtl/bcd_div10.sv
module bcd_div10 #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] q_o,
  output logic [3:0]   r_o
);
  logic [W-1:0] prod;
  logic [W-1:0] rem;
  always_comb begin
    q_o  = x_i / W'(10);
    prod = q_o * W'(10);
    rem  = x_i - prod;
    r_o  = rem[3:0];
  end
endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
  import bcd_pkg::*;
#(
  parameter int NSTEP = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fault_i,
  output logic accept_o,
  output logic run_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NSTEP - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    accept_o = (state_q == ST_IDLE) && start_i;
    run_o    = (state_q == ST_RUN);
    last_o   = run_o && (cnt_q == CNT_LAST);
    done_o   = (state_q == ST_FIN);
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = fault_i ? ST_FIN : ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcd_packer.sv
module bcd_packer
  import bcd_pkg::*;
#(
  parameter int VW = bcd_pkg::VAL_W,
  parameter int ND = bcd_pkg::NDIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [VW-1:0] value_i,
  input  logic          src_invalid_i,
  input  logic          stack_empty_i,
  input  logic          inv_mask_i,
  output logic [63:0]   lo_o,
  output logic [15:0]   hi_o,
  output logic          wr_en_o,
  output logic          invalid_o,
  output logic          done_o
);
  localparam int ACC_W = ND * DIG_W;
  localparam int TOP_W = ACC_W - LO_W;
  localparam int PAD_W = HI_W - 1 - TOP_W;

  // reset: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [VW-1:0] mag;
  logic          neg, over, fault;
  logic          accept, run, last, fin;

  bcd_range_check #(.W(VW), .LIMIT(VW'(MAG_LIMIT))) u_range (
    .value_i (value_i),
    .mag_o   (mag),
    .neg_o   (neg),
    .over_o  (over)
  );

  assign fault = over | src_invalid_i | stack_empty_i;

  bcd_seq_ctrl #(.NSTEP(ND)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .fault_i  (fault),
    .accept_o (accept),
    .run_o    (run),
    .last_o   (last),
    .done_o   (fin)
  );

  logic [VW-1:0]    work_q, work_d, quot;
  logic [3:0]       rem;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             sign_q, sign_d;
  logic             inv_q, inv_d, wr_q, wr_d;
  logic [LO_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             work_en, flag_en, res_en;

  bcd_div10 #(.W(VW)) u_div (
    .x_i (work_q),
    .q_o (quot),
    .r_o (rem)
  );

  always_comb begin
    work_d  = work_q;
    acc_d   = acc_q;
    sign_d  = sign_q;
    inv_d   = inv_q;
    wr_d    = wr_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    work_en = 1'b0;
    flag_en = 1'b0;
    res_en  = 1'b0;
    if (accept) begin
      flag_en = 1'b1;
      if (fault) begin
        inv_d = 1'b1;
        wr_d  = inv_mask_i;
        if (inv_mask_i) begin
          res_en = 1'b1;
          lo_d   = INDEF_LO;
          hi_d   = INDEF_HI;
        end
      end else begin
        work_en = 1'b1;
        work_d  = mag;
        acc_d   = '0;
        sign_d  = neg;
        inv_d   = 1'b0;
        wr_d    = 1'b1;
      end
    end else if (run) begin
      work_en = 1'b1;
      work_d  = quot;
      acc_d   = {rem, acc_q[ACC_W-1:DIG_W]};
      if (last) begin
        res_en = 1'b1;
        lo_d   = acc_d[LO_W-1:0];
        hi_d   = {sign_q, {PAD_W{1'b0}}, acc_d[ACC_W-1:LO_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      work_q <= '0;
      acc_q  <= '0;
      sign_q <= 1'b0;
    end else if (work_en) begin
      work_q <= work_d;
      acc_q  <= acc_d;
      sign_q <= sign_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      inv_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (flag_en) begin
      inv_q <= inv_d;
      wr_q  <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (res_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign done_o    = fin;
  assign wr_en_o   = fin & wr_q;
  assign invalid_o = fin & inv_q;
endmodule

// File: rtl/bcd_packer_chk.sv
module bcd_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        wr_en_o,
  input logic        invalid_o,
  input logic [63:0] lo_o,
  input logic [15:0] hi_o
);
  function automatic logic all_decimal(input logic [63:0] lo, input logic [15:0] hi);
    logic ok;
    ok = (hi[3:0] <= 4'd9) && (hi[7:4] <= 4'd9);
    for (int i = 0; i < 16; i++) ok = ok && (lo[4*i +: 4] <= 4'd9);
    return ok;
  endfunction

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_WR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o); // R10
  AST_INV_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> done_o); // R10
  AST_INDEF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && invalid_o) |-> (hi_o == 16'hFFFF && lo_o == 64'hC000_0000_0000_0000)); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !invalid_o) |-> (hi_o[14:8] == 7'd0)); // R2
  AST_DIGITS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !invalid_o) |-> all_decimal(lo_o, hi_o)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(lo_o) && $stable(hi_o)) |-> wr_en_o); // R6
endmodule

bind bcd_packer bcd_packer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .invalid_o (invalid_o),
  .lo_o      (lo_o),
  .hi_o      (hi_o)
);

// File: tb/bcd_packer_bench.sv
module bcd_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [63:0] value_i;
  logic        src_invalid_i, stack_empty_i, inv_mask_i;
  logic [63:0] lo_o;
  logic [15:0] hi_o;
  logic        wr_en_o, invalid_o, done_o;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          cyc      = 0;
  logic [63:0] prev_lo  = '0;
  logic [15:0] prev_hi  = '0;
  localparam logic [63:0] LIM = 64'd999999999999999999;

  always #5 clk = ~clk;

  bcd_packer u_bcd_packer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .src_invalid_i(src_invalid_i), .stack_empty_i(stack_empty_i),
    .inv_mask_i(inv_mask_i), .lo_o(lo_o), .hi_o(hi_o),
    .wr_en_o(wr_en_o), .invalid_o(invalid_o), .done_o(done_o)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_conv(input logic [63:0] v, input logic si, input logic se,
                         input logic m, input string req);
    logic [63:0] mag, t, elo;
    logic [15:0] ehi;
    logic        flt, ew, ei, seen;
    int          lat;
    mag = v[63] ? (~v + 64'd1) : v;
    flt = si | se | (mag > LIM);
    t   = mag;
    elo = '0;
    ehi = '0;
    for (int i = 0; i < 16; i++) begin
      elo[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    ehi[3:0]  = 4'(t % 10);
    t = t / 10;
    ehi[7:4]  = 4'(t % 10);
    ehi[15]   = v[63];
    if (flt) begin
      ei = 1'b1;
      ew = m;
      if (m) begin elo = 64'hC000_0000_0000_0000; ehi = 16'hFFFF; end
      else   begin elo = prev_lo; ehi = prev_hi; end
    end else begin
      ei = 1'b0;
      ew = 1'b1;
    end
    lat = flt ? 0 : 18;
    @(negedge clk);
    value_i = v; src_invalid_i = si; stack_empty_i = se; inv_mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < lat; i++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R9", "early done", 80'(seen), 80'(0));
    chk(done_o == 1'b1, "R9", "done at latency", 80'(done_o), 80'(1));
    chk(wr_en_o == ew, req, "write enable", 80'(wr_en_o), 80'(ew));
    chk(invalid_o == ei, req, "invalid", 80'(invalid_o), 80'(ei));
    chk({hi_o, lo_o} == {ehi, elo}, req, "result", {hi_o, lo_o}, {ehi, elo});
    @(negedge clk);
    chk(!done_o && !wr_en_o && !invalid_o, "R10", "pulse width",
        80'({done_o, wr_en_o, invalid_o}), 80'(0));
    if (ew) begin prev_lo = elo; prev_hi = ehi; end
  endtask

  task automatic t_reset();
    chk(!done_o && !wr_en_o && !invalid_o, "R1", "flags after reset",
        80'({done_o, wr_en_o, invalid_o}), 80'(0));
    chk({hi_o, lo_o} == 80'd0, "R1", "result after reset", {hi_o, lo_o}, 80'd0);
  endtask

  task automatic t_positive();
    do_conv(64'd123456789012345678, 1'b0, 1'b0, 1'b1, "R2");
    do_conv(64'd0, 1'b0, 1'b0, 1'b1, "R2");
    do_conv(64'd907, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_negative();
    do_conv(-64'sd42, 1'b0, 1'b0, 1'b1, "R3");
    do_conv(-64'sd999999999999999999, 1'b0, 1'b0, 1'b1, "R3");
  endtask

  task automatic t_range();
    do_conv(LIM, 1'b0, 1'b0, 1'b1, "R4");
    do_conv(LIM + 64'd1, 1'b0, 1'b0, 1'b1, "R4");
    do_conv(64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_masked();
    do_conv(64'hFFFF_FFFF_FFFF_FFFF >> 1, 1'b0, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_unmasked();
    do_conv(64'd55, 1'b0, 1'b0, 1'b1, "R2");
    do_conv(LIM + 64'd7, 1'b0, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_empty();
    do_conv(64'd12, 1'b0, 1'b1, 1'b1, "R7");
    do_conv(64'd13, 1'b0, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_upstream();
    do_conv(64'd77, 1'b1, 1'b0, 1'b1, "R8");
    do_conv(64'd78, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_busy();
    logic seen;
    @(negedge clk);
    value_i = 64'd31415926; src_invalid_i = 1'b0; stack_empty_i = 1'b0;
    inv_mask_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    value_i = 64'd1; stack_empty_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stack_empty_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R11", "no done from ignored start", 80'(seen), 80'(0));
    chk(done_o && wr_en_o && !invalid_o, "R11", "first run completes",
        80'({done_o, wr_en_o, invalid_o}), 80'(3'b110));
    chk({hi_o, lo_o} == {16'h0000, 64'h0000_0000_3141_5926}, "R11", "first run result",
        {hi_o, lo_o}, {16'h0000, 64'h0000_0000_3141_5926});
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    chk(!seen, "R11", "no trailing done", 80'(seen), 80'(0));
    prev_lo = 64'h0000_0000_3141_5926;
    prev_hi = 16'h0000;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; value_i = '0;
    src_invalid_i = 1'b0; stack_empty_i = 1'b0; inv_mask_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_range();
    t_masked();
    t_unmasked();
    t_empty();
    t_upstream();
    t_busy();
    summary();
  end
endmodule